// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the speed of a fan that has a logic-level tachometer output. It measures the time from one rising tach edge to the next by counting ticks of a slow reference. Because it counts time per revolution, a larger count means a slower fan. The reference tick is made by dividing the system clock down to a base rate of about 45 kHz (`BASE_DIV` system cycles per base tick). The selected divisor then divides that base rate again, so divisor 2 gives the nominal 22.5 kHz count rate. For a fan that gives two pulses per revolution, the count is roughly 1,350,000 / (rpm × divisor). A 4400 rpm fan reads about 153, and a fan at 70 % of that speed reads about 219. A fan that gives one pulse per revolution should use twice the divisor to read the same value.

The raw tach input has slow edges and may be noisy. It passes through a two-flop synchroniser and then a three-sample majority filter before edge detection. Each finished period count is stored in an output register that holds its value until the next period ends. When a stored count reaches the programmed limit, a sticky alarm flag is set. The interrupt output shows that flag unless the mask bit blocks it.

Top module: `fan_tach_monitor`

## Requirements
- R1: After reset, `count` is 0, `status` is 0 and `irq` is 0.
- R2: The first filtered rising edge only starts a measurement. Every later rising edge stores the number of completed count ticks since the previous rising edge in `count`. For an edge-to-edge period of P system clocks, that number is floor((P-1)/(BASE_DIV·d)), where d is the divisor.
- R3: The running count saturates at 255 and never wraps. A period too long for 8 bits reads 255.
- R4: `divSel` selects the divisor d as follows: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8. The divisor field is expected to power up at 2'b01.
- R5: The filter ignores a tach pulse or dip that lasts a single system cycle. A one-cycle bounce at an edge (1,0,1 on a rise or 0,1,0 on a fall) produces exactly one edge, so the measured period does not change.
- R6: `count` changes only when a period ends. It stays stable while the next period is being counted.
- R7: When a stored count is greater than or equal to `limit`, `status` sets one cycle after the store. A stored count below `limit` leaves `status` unchanged.
- R8: `status` stays set until `statusClr` is pulsed in a cycle with no store. After a clear it stays 0, even if `count` still meets the limit, until the next store that meets the limit.
- R9: `irq` is high exactly when `status` is 1 and `irqMask` is 0. An `irqMask` of 1 blocks the interrupt but does not change `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tachIn | input | 1 | Raw tachometer level, asynchronous |
| divSel | input | 2 | Divisor select, encoded as in R4 |
| limit | input | CNT_W | Alarm threshold for the stored count |
| irqMask | input | 1 | 1 blocks the interrupt output |
| statusClr | input | 1 | One-cycle strobe that clears the alarm flag |
| count | output | CNT_W | Count from the last finished period |
| status | output | 1 | Sticky alarm flag |
| irq | output | 1 | Interrupt output, active high |

## Verification
If the prescaler phase is wrong or the divisor is decoded wrongly, the stored count is off by a whole factor or by one. That shows in `count` on the first full period after the fault, about five cycles after the tach edge. A filter or edge-detector fault adds extra stores or loses some. That shows as a changed or halved count, or as a `count` that moves in the middle of a period. Faults in the alarm path appear at the stores: the flag sets on a count below the limit, fails to set on one above it, comes back without a store after a clear, or `irq` is wrong for a given mask setting.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

  // Strobes sent from the control half to the datapath half.
  typedef struct packed {
    logic clrCount;   // a period boundary: restart the running count
    logic incCount;   // one count tick has elapsed
    logic latchCount; // store the running count (the period is complete)
  } tachStrobes_t;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

endpackage

// File: rtl/fan_tach_ctrl.sv
module fan_tach_ctrl
  import fan_tach_pkg::*;
#(
  parameter int BASE_DIV = 2778,
  parameter int MAX_SHIFT = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tachIn,
  input  logic [1:0]   divSel,
  output tachStrobes_t strb
);

  localparam int MAX_LEN = BASE_DIV << MAX_SHIFT;
  localparam int PRE_W   = $clog2(MAX_LEN);

  logic             syncA, syncB;
  logic [2:0]       hist;
  logic             filt, filtPrev;
  logic             armed;
  logic [PRE_W-1:0] presc;
  logic [PRE_W:0]   tickLen;
  logic             rise, tick;

  // Input synchroniser and three-sample majority filter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      hist     <= '0;
      filt     <= 1'b0;
      filtPrev <= 1'b0;
    end else begin
      syncA    <= tachIn;
      syncB    <= syncA;
      hist     <= {hist[1:0], syncB};
      filt     <= maj3(hist);
      filtPrev <= filt;
    end
  end

  assign rise = filt & ~filtPrev;

  // Prescaler length in system cycles for the chosen divisor.
  always_comb begin
    tickLen = (PRE_W+1)'(BASE_DIV) << divSel;
  end

  assign tick = ({1'b0, presc} == (tickLen - (PRE_W+1)'(1)));

  // The prescaler restarts at every period boundary, so the count is
  // exact and does not depend on the prescaler phase.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc <= '0;
      armed <= 1'b0;
    end else begin
      if (rise || tick) presc <= '0;
      else              presc <= presc + 1'b1;
      if (rise) armed <= 1'b1;
    end
  end

  always_comb begin
    strb.clrCount   = rise;
    strb.incCount   = tick & ~rise;
    strb.latchCount = rise & armed;
  end

endmodule

// File: rtl/fan_tach_datapath.sv
module fan_tach_datapath
  import fan_tach_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tachStrobes_t     strb,
  input  logic [CNT_W-1:0] limit,
  input  logic             irqMask,
  input  logic             statusClr,
  output logic [CNT_W-1:0] runCount,
  output logic [CNT_W-1:0] count,
  output logic             status,
  output logic             irq
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic atMax;
  logic meetsLimit;

  assign atMax      = (runCount == CNT_MAX);
  assign meetsLimit = (runCount >= limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCount <= '0;
      count    <= '0;
      status   <= 1'b0;
    end else begin
      if (strb.latchCount) count <= runCount;

      if (strb.clrCount)                runCount <= '0;
      else if (strb.incCount && !atMax) runCount <= runCount + 1'b1;

      // A store that meets the limit has priority over a clear.
      if (strb.latchCount && meetsLimit) status <= 1'b1;
      else if (statusClr)                status <= 1'b0;
    end
  end

  assign irq = status & ~irqMask;

endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor
  import fan_tach_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int BASE_DIV = 2778
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tachIn,
  input  logic [1:0]       divSel,
  input  logic [CNT_W-1:0] limit,
  input  logic             irqMask,
  input  logic             statusClr,
  output logic [CNT_W-1:0] count,
  output logic             status,
  output logic             irq
);

  tachStrobes_t     strb;
  logic [CNT_W-1:0] runCount;

  fan_tach_ctrl #(
    .BASE_DIV (BASE_DIV),
    .MAX_SHIFT(3)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .tachIn(tachIn),
    .divSel(divSel),
    .strb  (strb)
  );

  fan_tach_datapath #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .limit    (limit),
    .irqMask  (irqMask),
    .statusClr(statusClr),
    .runCount (runCount),
    .count    (count),
    .status   (status),
    .irq      (irq)
  );

endmodule

// File: rtl/fan_tach_checker.sv
module fan_tach_checker
  import fan_tach_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input tachStrobes_t     strb,
  input logic [CNT_W-1:0] runCount,
  input logic [CNT_W-1:0] count,
  input logic             status,
  input logic             statusClr,
  input logic             irqMask,
  input logic             irq
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.incCount && strb.clrCount));

  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (runCount == CNT_MAX && !strb.clrCount) |=> (runCount == CNT_MAX));

  p_count_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchCount |=> $stable(count));

  p_set_on_store_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status) |-> $past(strb.latchCount));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statusClr && !strb.latchCount) |=> !status);

  p_mask_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqMask |-> !irq);

endmodule

bind fan_tach_monitor fan_tach_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .strb     (strb),
  .runCount (runCount),
  .count    (count),
  .status   (status),
  .statusClr(statusClr),
  .irqMask  (irqMask),
  .irq      (irq)
);

// File: tb/tb_fan_tach_monitor.sv
module tb_fan_tach_monitor;

  localparam int BASE = 4;
  localparam int CW   = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tachIn = 1'b0;
  logic [1:0]    divSel = 2'b01;
  logic [CW-1:0] limit = 8'hFF;
  logic          irqMask = 1'b0;
  logic          statusClr = 1'b0;
  logic [CW-1:0] count;
  logic          status;
  logic          irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  fan_tach_monitor #(.CNT_W(CW), .BASE_DIV(BASE)) dut (
    .clk(clk), .rstN(rstN), .tachIn(tachIn), .divSel(divSel),
    .limit(limit), .irqMask(irqMask), .statusClr(statusClr),
    .count(count), .status(status), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int expCount(input int p, input logic [1:0] sel);
    int n = (p - 1) / (BASE << sel);
    return (n > 255) ? 255 : n;
  endfunction

  // Tach level at cycle c of a period of p cycles (high for the first half).
  function automatic logic levelAt(input int c, input int p, input bit noisy);
    int h = p / 2;
    logic v = (c < h);
    if (noisy && (c == 1 || c == h + 1 || c == h / 2 || c == h + (p - h) / 2))
      v = ~v;
    return v;
  endfunction

  task automatic runPeriods(input int p, input bit noisy, input int n);
    for (int k = 0; k < n; k++)
      for (int c = 0; c < p; c++) begin
        tachIn = levelAt(c, p, noisy);
        @(negedge clk);
      end
  endtask

  // Runs two periods, then one more period with checks on its edge.
  task automatic measure(input int p, input logic [1:0] sel, input bit noisy, input string req);
    int exp = expCount(p, sel);
    divSel = sel;
    runPeriods(p, noisy, 2);
    for (int c = 0; c < p; c++) begin
      tachIn = levelAt(c, p, noisy);
      @(negedge clk);
      if (c == 10) check(count == exp, req, count, exp);
      if (c == p - 2) check(count == exp, "R6 count held mid-period", count, exp);
    end
  endtask

  task automatic pulseClr();
    statusClr = 1'b1;
    @(negedge clk);
    statusClr = 1'b0;
  endtask

  task automatic testReset();
    check(count == 0, "R1 count after reset", count, 0);
    check(status == 0, "R1 status after reset", status, 0);
    check(irq == 0, "R1 irq after reset", irq, 0);
  endtask

  task automatic testDivisors();
    measure(101,  2'b00, 1'b0, "R2 R4 divisor 1");
    measure(1225, 2'b01, 1'b0, "R2 R4 divisor 2 nominal 153");
    measure(2453, 2'b10, 1'b0, "R4 divisor 4 one-pulse fan 153");
    measure(2000, 2'b11, 1'b0, "R4 divisor 8");
    measure(1753, 2'b01, 1'b0, "R2 slowed fan 219");
  endtask

  task automatic testSaturate();
    measure(9000, 2'b11, 1'b0, "R3 saturation at 255");
  endtask

  task automatic testNoise();
    measure(1225, 2'b01, 1'b1, "R5 glitches and bounce ignored");
  endtask

  task automatic testAlarm();
    limit = 8'd200;
    irqMask = 1'b0;
    pulseClr();
    check(status == 0, "R8 clear with no store", status, 0);
    measure(1753, 2'b01, 1'b0, "R2 count 219 for alarm");
    check(status == 1, "R7 set when count meets limit", status, 1);
    check(irq == 1, "R9 irq unmasked", irq, 1);
    pulseClr();
    check(status == 0, "R8 cleared by strobe", status, 0);
    check(irq == 0, "R9 irq follows cleared status", irq, 0);
    repeat (100) @(negedge clk);
    check(status == 0, "R8 stays clear without a store", status, 0);
    irqMask = 1'b1;
    tachIn = 1'b1;
    repeat (10) @(negedge clk);
    check(status == 1, "R8 sets again on next qualifying store", status, 1);
    check(irq == 0, "R9 mask blocks irq", irq, 0);
    irqMask = 1'b0;
    @(negedge clk);
    check(irq == 1, "R9 unmask shows irq", irq, 1);
    runPeriods(1753, 1'b0, 1);
    limit = 8'd250;
    pulseClr();
    measure(1225, 2'b01, 1'b0, "R2 count 153 below limit");
    check(status == 0, "R7 no set below limit", status, 0);
    check(irq == 0, "R9 no irq below limit", irq, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog all-requirements act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDivisors();
    testSaturate();
    testNoise();
    testAlarm();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule